// File: doc/BRIEF.md
# Thermal and Supply Fault Supervisor

This block merges temperature and supply health into a single registered disable for a three-phase motor driver. A digitised junction temperature code is compared against a trip code and a lower recovery code. The resulting over-temperature flag keeps its state anywhere between the two codes, so it has hysteresis. Four digital comparator flags report supply health: the main supply above its low threshold, the main supply above its high threshold, the internal regulator rail good and the Hall-bias rail good. Each flag is synchronised and debounced before the supply lockout state machine uses it.

The lockout trips when the main supply drops below its low threshold or when either auxiliary rail is lost. It clears only when the main supply is above its high threshold and the regulator and Hall-bias rails are also good. A regulator or bias rail that comes up later than the main supply therefore holds the driver off. Both faults recover by themselves once their conditions clear, and no clear input is needed. After reset the lockout is active and the driver is disabled.

Top module: `drv_fault_sup`

## Requirements
- R1: With the default parameters (10-bit code, 0.25 °C per LSB), the trip code is 700 and the recovery code is 600. A temperature code equal to or above the trip code sets `therm_flt` on the next clock edge.
- R2: Once set, `therm_flt` clears only on the edge after a code strictly below the recovery code. A code from the recovery code up to the trip code minus one leaves `therm_flt` unchanged in both directions.
- R3: `drv_off` is a register that, one clock after the fact, is high whenever `therm_flt` or `uv_flt` was high. It is low otherwise.
- R4: When the lockout is clear, it sets if the qualified `vcc_lo_ok`, `vreg_ok` or `vhb_ok` is low.
- R5: When the lockout is set, it clears only if the qualified `vcc_hi_ok`, `vcc_lo_ok`, `vreg_ok` and `vhb_ok` are all high. A late regulator or bias rail keeps `uv_flt` high even after the main supply has recovered.
- R6: Each supply flag passes through a SYNC_STAGES flop synchroniser and then a debounce stage. The debounce stage takes a new value only after that value has been present for DEB_CYCLES consecutive cycles. An input change shows on `uv_flt` SYNC_STAGES+DEB_CYCLES+1 edges later. An input pulse shorter than DEB_CYCLES cycles has no effect on `uv_flt`.
- R7: During and right after reset, `uv_flt`=1, `drv_off`=1 and `therm_flt`=0.
- R8: Recovery is automatic. Once the temperature and rails are healthy, `drv_off` returns low with no other input action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | TEMP_W | Junction temperature code, synchronous to clk |
| vcc_lo_ok | input | 1 | Main supply above its low threshold (asynchronous) |
| vcc_hi_ok | input | 1 | Main supply above its high threshold (asynchronous) |
| vreg_ok | input | 1 | Internal regulator rail good (asynchronous) |
| vhb_ok | input | 1 | Hall-bias rail good (asynchronous) |
| drv_off | output | 1 | Registered disable that forces all driver outputs low |
| therm_flt | output | 1 | Over-temperature fault flag |
| uv_flt | output | 1 | Undervoltage lockout flag |

## Verification
The assertions assume that `temp_code` is already synchronous to the clock. They also assume that the two main-supply comparators are consistent, meaning `vcc_hi_ok` high implies `vcc_lo_ok` high. The stimulus changes the temperature only at the falling edge. It never applies the inconsistent comparator pattern: out of all sixteen flag combinations it uses only the twelve legal ones. Every supply change is held for at least the full qualification window, except in the glitch tests, which deliberately stay just under or exactly at the debounce length.

// File: rtl/sup_pkg.sv
package sup_pkg;
   localparam int SENSE_N  = 4;
   localparam int IDX_LO   = 0;
   localparam int IDX_HI   = 1;
   localparam int IDX_REG  = 2;
   localparam int IDX_HB   = 3;
endpackage

// File: rtl/sup_rail_qual.sv
module sup_rail_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic good_o
);
   localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("DEB_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   s_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end
   assign s_sync = sync_q[SYNC_STAGES-1];

   if (DEB_CYCLES == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) good_o <= 1'b0;
         else        good_o <= s_sync;
      end
   end else begin : g_count
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q  <= '0;
            good_o <= 1'b0;
         end else if (s_sync != good_o) begin
            if (cnt_q == CW'(DEB_CYCLES - 1)) begin
               cnt_q  <= '0;
               good_o <= s_sync;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            cnt_q <= '0;
         end
      end

      // R6: the counter never runs past its limit
      p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= CW'(DEB_CYCLES - 1));
   end

   // R6: a change of the qualified flag always follows the synchronised input
   p_follow_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(good_o) |-> good_o == $past(s_sync));
endmodule

// File: rtl/sup_therm_hyst.sv
module sup_therm_hyst #(
   parameter int TEMP_W    = 10,
   parameter int HOT_CODE  = 700,
   parameter int COOL_CODE = 600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp_i,
   output logic              hot_o
);
   if (HOT_CODE <= COOL_CODE) begin : g_bad_band
      $error("HOT_CODE must exceed COOL_CODE");
   end
   if (HOT_CODE >= (1 << TEMP_W)) begin : g_bad_hot
      $error("HOT_CODE does not fit TEMP_W");
   end

   localparam logic [TEMP_W-1:0] HOT_C  = TEMP_W'(HOT_CODE);
   localparam logic [TEMP_W-1:0] COOL_C = TEMP_W'(COOL_CODE);

   logic trip, cool;
   assign trip = (temp_i >= HOT_C);
   assign cool = (temp_i <  COOL_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            hot_o <= 1'b0;
      else if (!hot_o && trip) hot_o <= 1'b1;
      else if (hot_o && cool)  hot_o <= 1'b0;
   end

   // R1: a code at or above the trip point always leads to a fault
   p_trip_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_i >= HOT_C) |=> hot_o);
   // R2: inside the band the flag holds its state
   p_band_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_i >= COOL_C && temp_i < HOT_C) |=> $stable(hot_o));
endmodule

// File: rtl/sup_uvlo.sv
module sup_uvlo
   import sup_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SENSE_N-1:0] good_i,
   output logic               lock_o
);
   logic all_good, any_lost;
   assign all_good = &good_i;
   assign any_lost = !good_i[IDX_LO] || !good_i[IDX_REG] || !good_i[IDX_HB];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 lock_o <= 1'b1;
      else if (lock_o && all_good) lock_o <= 1'b0;
      else if (!lock_o && any_lost) lock_o <= 1'b1;
   end

   // R5: lockout never releases while an auxiliary rail or the high comparator is bad
   p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_o) |-> $past(good_i[IDX_HI] && good_i[IDX_REG] && good_i[IDX_HB]));
   // R4: losing the low comparator while running always trips
   p_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_o && !good_i[IDX_LO]) |=> lock_o);
endmodule

// File: rtl/drv_fault_sup.sv
module drv_fault_sup
   import sup_pkg::*;
#(
   parameter int TEMP_W      = 10,
   parameter int HOT_CODE    = 700,
   parameter int COOL_CODE   = 600,
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp_code,
   input  logic              vcc_lo_ok,
   input  logic              vcc_hi_ok,
   input  logic              vreg_ok,
   input  logic              vhb_ok,
   output logic              drv_off,
   output logic              therm_flt,
   output logic              uv_flt
);
   logic [SENSE_N-1:0] raw_s, good_s;

   always_comb begin
      raw_s          = '0;
      raw_s[IDX_LO]  = vcc_lo_ok;
      raw_s[IDX_HI]  = vcc_hi_ok;
      raw_s[IDX_REG] = vreg_ok;
      raw_s[IDX_HB]  = vhb_ok;
   end

   for (genvar i = 0; i < SENSE_N; i++) begin : g_qual
      sup_rail_qual #(
         .SYNC_STAGES(SYNC_STAGES),
         .DEB_CYCLES (DEB_CYCLES)
      ) u_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (raw_s[i]),
         .good_o(good_s[i])
      );
   end

   sup_therm_hyst #(
      .TEMP_W   (TEMP_W),
      .HOT_CODE (HOT_CODE),
      .COOL_CODE(COOL_CODE)
   ) u_therm (
      .clk   (clk),
      .rst_n (rst_n),
      .temp_i(temp_code),
      .hot_o (therm_flt)
   );

   sup_uvlo u_uvlo (
      .clk   (clk),
      .rst_n (rst_n),
      .good_i(good_s),
      .lock_o(uv_flt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_off <= 1'b1;
      else        drv_off <= therm_flt | uv_flt;
   end

   // R3: a hot code at the input disables the driver two edges later
   p_hot_kills_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (temp_code >= TEMP_W'(HOT_CODE)) |=> ##1 drv_off);
   // R3: the driver is only enabled when neither fault was present
   p_enable_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drv_off) |-> $past(!therm_flt && !uv_flt));
endmodule

// File: tb/tb_drv_fault_sup.sv
module tb_drv_fault_sup;
   localparam int TW = 10, HOT = 700, COOL = 600, SYN = 2, DEB = 4;
   localparam int UV_LAT = SYN + DEB + 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [TW-1:0] temp_code = '0;
   logic vcc_lo_ok = 0, vcc_hi_ok = 0, vreg_ok = 0, vhb_ok = 0;
   logic drv_off, therm_flt, uv_flt;
   int total = 0, bad = 0;

   drv_fault_sup #(.TEMP_W(TW), .HOT_CODE(HOT), .COOL_CODE(COOL),
                   .SYNC_STAGES(SYN), .DEB_CYCLES(DEB)) dut (
      .clk(clk), .rst_n(rst_n), .temp_code(temp_code),
      .vcc_lo_ok(vcc_lo_ok), .vcc_hi_ok(vcc_hi_ok), .vreg_ok(vreg_ok), .vhb_ok(vhb_ok),
      .drv_off(drv_off), .therm_flt(therm_flt), .uv_flt(uv_flt));

   always #10 clk = ~clk;

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic rails(input logic lo, input logic hi, input logic rg, input logic hb);
      vcc_lo_ok = lo; vcc_hi_ok = hi; vreg_ok = rg; vhb_ok = hb;
   endtask

   initial begin
      #(20 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic hot, prev_hot, uv, nuv;
      rails(1, 1, 1, 1);
      step(3);
      chk("R7", "uv_flt in reset", uv_flt, 1);
      chk("R7", "drv_off in reset", drv_off, 1);
      chk("R7", "therm_flt in reset", therm_flt, 0);
      rst_n = 1'b1;
      step(1);
      chk("R7", "uv_flt after reset", uv_flt, 1);
      chk("R7", "drv_off after reset", drv_off, 1);
      chk("R7", "therm_flt after reset", therm_flt, 0);
      step(UV_LAT + 3);
      chk("R8", "uv_flt released", uv_flt, 0);
      chk("R8", "drv_off released", drv_off, 0);

      // temperature sweep up then down
      hot = 0; prev_hot = 0;
      for (int c = 0; c < (1 << TW); c++) begin
         temp_code = TW'(c);
         step(1);
         if (!hot && c >= HOT) hot = 1;
         chk("R1", "therm_flt rising sweep", therm_flt, int'(hot));
         chk("R3", "drv_off rising sweep", drv_off, int'(prev_hot));
         prev_hot = hot;
      end
      for (int c = (1 << TW) - 1; c >= 0; c--) begin
         temp_code = TW'(c);
         step(1);
         if (hot && c < COOL) hot = 0;
         chk("R2", "therm_flt falling sweep", therm_flt, int'(hot));
         chk("R3", "drv_off falling sweep", drv_off, int'(prev_hot));
         prev_hot = hot;
      end
      step(1);
      chk("R8", "drv_off after cooling", drv_off, 0);

      // band re-entry: heat, drop into band, must hold
      temp_code = TW'(HOT); step(1);
      temp_code = TW'(COOL); step(3);
      chk("R2", "therm_flt held at cool code", therm_flt, 1);
      temp_code = TW'(COOL - 1); step(1);
      chk("R2", "therm_flt clear below cool", therm_flt, 0);
      temp_code = TW'(HOT - 1); step(3);
      chk("R2", "therm_flt stays clear in band", therm_flt, 0);
      temp_code = '0; step(2);

      // supply combination sweep from locked and unlocked starting points
      for (int base = 0; base < 2; base++) begin
         for (int c = 0; c < 16; c++) begin
            logic lo, hi, rg, hb;
            lo = c[0]; hi = c[1]; rg = c[2]; hb = c[3];
            if (hi && !lo) continue;
            rails(base[0], base[0], base[0], base[0]);
            step(UV_LAT + 4);
            uv = (base == 0);
            chk("R4", "uv_flt base state", uv_flt, int'(uv));
            nuv = uv ? !(lo && hi && rg && hb) : (!lo || !rg || !hb);
            rails(lo, hi, rg, hb);
            step(UV_LAT - 1);
            chk("R6", "uv_flt before qualify", uv_flt, int'(uv));
            step(1);
            chk(uv ? "R5" : "R4", "uv_flt after qualify", uv_flt, int'(nuv));
            step(1);
            chk("R3", "drv_off follows uv", drv_off, int'(nuv));
         end
      end

      // late regulator: main supply good first
      rails(0, 0, 0, 0); step(UV_LAT + 4);
      rails(1, 1, 0, 1); step(UV_LAT + 10);
      chk("R5", "late regulator holds lock", uv_flt, 1);
      rails(1, 1, 1, 0); step(UV_LAT + 10);
      chk("R5", "late bias holds lock", uv_flt, 1);
      rails(1, 1, 1, 1); step(UV_LAT + 1);
      chk("R8", "release without clear", drv_off, 0);

      // glitch shorter than debounce is ignored
      vreg_ok = 0; step(DEB - 1); vreg_ok = 1;
      for (int i = 0; i < UV_LAT + 6; i++) begin
         step(1);
         chk("R6", "short glitch ignored", uv_flt, 0);
      end
      // glitch of exactly the debounce length trips
      vreg_ok = 0; step(DEB); vreg_ok = 1;
      step(UV_LAT - DEB);
      chk("R6", "full-length glitch trips", uv_flt, 1);
      step(UV_LAT + 4);
      chk("R8", "recovers after glitch", uv_flt, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule